// File: doc/BRIEF.md
# Mu-law / A-law Sample Converter

This block moves audio samples between 16-bit two's-complement linear PCM and 8-bit companded codes, with either of the two common telephony laws selectable per sample. Every word on both sides is 16 bits wide. On the companded side the 8-bit code sits in the low byte of the word. The linear side always keeps full 16-bit framing: a sample being compressed is first truncated to the resolution of the chosen law and then encoded. An expanded sample comes out left-justified, with its unused low bits zero.

Each accepted word carries its own law select and direction select, so consecutive samples may use different laws or directions. There is one register stage between input and output. A result appears on the clock after the input was taken and is marked by an output valid flag. The output word holds its value while no new input arrives.

Top module: `pcm_compander`

## Requirements
- R1: While rst_n is low, and on the first clock after it is released with no input, out_valid is 0 and out_word is 16'h0000.
- R2: out_valid is 1 on the clock edge after one at which in_valid was 1, and 0 after an edge at which in_valid was 0. There is exactly one cycle of latency.
- R3: in_law (0 = mu-law, 1 = A-law) and in_dir (0 = expand, 1 = compress) are sampled on the same edge as in_word. Changing them on every cycle gives the correct result for each individual sample.
- R4: A mu-law expansion takes its code from in_word[7:0] and ignores in_word[15:8]. The code is inverted on all 8 bits, then bit 7 gives the sign (1 = negative), bits 6:4 the segment and bits 3:0 the step. The output is the 16-bit linear value, with bits 1:0 always zero. Code 8'h00 gives 16'h8284 and code 8'hFF gives 16'h0000.
- R5: An A-law expansion takes its code from in_word[7:0] and ignores in_word[15:8]. The code is XORed with 8'h55, then bit 7 gives the sign (1 = positive), bits 6:4 the segment and bits 3:0 the step. The output has bits 2:0 always zero. Code 8'hD5 gives 16'h0008 and code 8'h55 gives 16'hFFF8.
- R6: A mu-law compression uses in_word[15:2] as a 14-bit signed value. It takes the magnitude, clips it at 8159, adds a bias of 33, finds the segment and the 4 step bits, and inverts all 8 code bits, with bit 7 of the inverted result set for non-negative inputs. Input 16'h0000 gives 16'h00FF.
- R7: An A-law compression uses in_word[15:3] as a 13-bit signed value, with the one's-complement magnitude taken for negative values. It finds the segment and the step, and XORs the code with 8'hD5 for non-negative inputs and with 8'h55 for negative inputs. Input 16'h0000 gives 16'h00D5.
- R8: Every compressed result has out_word[15:8] equal to 8'h00.
- R9: The linear extremes saturate and never wrap. 16'h8000 gives 16'h0000 (mu-law) and 16'h002A (A-law). 16'h7FFF gives 16'h0080 (mu-law) and 16'h00AA (A-law).
- R10: While in_valid is 0, out_word keeps the value of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word and selects are valid this cycle |
| in_law | input | 1 | 0 = mu-law, 1 = A-law |
| in_dir | input | 1 | 0 = expand code to linear, 1 = compress linear to code |
| in_word | input | 16 | Linear sample, or companded code in bits 7:0 |
| out_valid | output | 1 | out_word carries a new result |
| out_word | output | 16 | Linear result, or code in bits 7:0 with bits 15:8 zero |

## Verification
All 256 codes are expanded under both laws, each with a non-zero upper byte. This shows whether the segment and step decode, the sign sense, the inversion mask and the ignored byte are each handled correctly. A compression sweep steps across the whole signed range with low-bit offsets that change from sample to sample. It separates correct truncation from rounding, and correct segment boundaries from off-by-one ones. Fixed points at zero, minus one and both extremes pin down the bias, the one's-complement and two's-complement magnitude paths, and saturation. A final stream switches law and direction on every sample and leaves gaps in the valid input, which exposes any select that is sampled late and any output that does not hold during a gap.

// File: rtl/pcm_compander_pkg.sv
package pcm_compander_pkg;

   localparam int unsigned LIN_W  = 16;
   localparam int unsigned CODE_W = 8;

   typedef enum logic {
      LAW_MU = 1'b0,
      LAW_A  = 1'b1
   } law_e;

   typedef enum logic {
      DIR_EXPAND   = 1'b0,
      DIR_COMPRESS = 1'b1
   } dir_e;

endpackage

// File: rtl/cmp_compress.sv
// Linear-to-code encoder; the law is chosen at elaboration.
module cmp_compress #(
   parameter bit IS_ALAW = 1'b0,
   parameter int WORD_W  = 16,
   parameter int CODE_W  = 8,
   parameter int MU_BIAS = 33,
   parameter int MU_CLIP = 8159
) (
   input  logic [WORD_W-1:0] lin,
   output logic [CODE_W-1:0] code
);

   if (WORD_W != 16 || CODE_W != 8) begin : g_bad_width
      $error("cmp_compress: only 16-bit linear / 8-bit code framing is supported");
   end

   if (!IS_ALAW) begin : g_mu
      localparam int TW = WORD_W - 2;
      logic signed [TW-1:0] trunc;
      logic                 neg;
      logic [TW:0]          mag;
      logic [TW-1:0]        biased;
      logic [3:0]           seg;
      logic [3:0]           mant;
      logic [CODE_W-1:0]    raw;
      logic                 unused_lo;

      assign unused_lo = ^lin[1:0];

      always_comb begin
         trunc = lin[WORD_W-1:2];
         neg   = trunc[TW-1];
         // magnitude in one extra bit so the most negative value cannot wrap
         mag   = neg ? (~{1'b1, trunc}) + 1'b1 : {1'b0, trunc};
         if (mag > (TW+1)'(MU_CLIP))
            mag = (TW+1)'(MU_CLIP);
         biased = mag[TW-1:0] + TW'(MU_BIAS);
         seg = 4'd0;
         for (int p = 6; p < TW; p++) begin
            if (biased[p]) seg = 4'(p - 5);
         end
         mant = 4'(biased >> (seg + 4'd1));
         raw  = seg[3] ? 8'h7F : {1'b0, seg[2:0], mant};
         code = raw ^ (neg ? 8'h7F : 8'hFF);
      end
   end else begin : g_a
      localparam int TW = WORD_W - 3;
      logic [TW-1:0]     trunc;
      logic              neg;
      logic [TW-2:0]     mag;
      logic [3:0]        seg;
      logic [3:0]        mant;
      logic [CODE_W-1:0] raw;
      logic              unused_lo;

      assign unused_lo = ^lin[2:0];

      always_comb begin
         trunc = lin[WORD_W-1:3];
         neg   = trunc[TW-1];
         mag   = neg ? ~trunc[TW-2:0] : trunc[TW-2:0];
         seg   = 4'd0;
         for (int p = 5; p < TW-1; p++) begin
            if (mag[p]) seg = 4'(p - 4);
         end
         mant = (seg < 4'd2) ? 4'(mag >> 1) : 4'(mag >> seg);
         raw  = {1'b0, seg[2:0], mant};
         code = raw ^ (neg ? 8'h55 : 8'hD5);
      end
   end

endmodule

// File: rtl/cmp_expand.sv
// Code-to-linear decoder; the law is chosen at elaboration.
module cmp_expand #(
   parameter bit IS_ALAW = 1'b0,
   parameter int WORD_W  = 16,
   parameter int CODE_W  = 8
) (
   input  logic [CODE_W-1:0] code,
   output logic [WORD_W-1:0] lin
);

   if (WORD_W != 16 || CODE_W != 8) begin : g_bad_width
      $error("cmp_expand: only 16-bit linear / 8-bit code framing is supported");
   end

   if (!IS_ALAW) begin : g_mu
      logic [CODE_W-1:0] u;
      logic [WORD_W-1:0] t;
      logic [WORD_W-1:0] mag;

      always_comb begin
         u   = ~code;
         t   = (WORD_W'({u[3:0], 3'b000}) + WORD_W'(132)) << u[6:4];
         mag = t - WORD_W'(132);
         lin = u[7] ? (WORD_W'(0) - mag) : mag;
      end
   end else begin : g_a
      logic [CODE_W-1:0] a;
      logic [WORD_W-1:0] t;

      always_comb begin
         a = code ^ 8'h55;
         if (a[6:4] == 3'd0)
            t = WORD_W'({a[3:0], 4'b0000}) + WORD_W'(8);
         else
            t = (WORD_W'({a[3:0], 4'b0000}) + WORD_W'(264)) << (a[6:4] - 3'd1);
         lin = a[7] ? t : (WORD_W'(0) - t);
      end
   end

endmodule

// File: rtl/pcm_compander.sv
module pcm_compander
   import pcm_compander_pkg::*;
#(
   parameter int WORD_W  = LIN_W,
   parameter int CODE_W  = pcm_compander_pkg::CODE_W,
   parameter int MU_BIAS = 33,
   parameter int MU_CLIP = 8159
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_law,
   input  logic              in_dir,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);

   localparam int NLAW   = 2;
   localparam int FILL_W = WORD_W - CODE_W;

   if (WORD_W != 16 || CODE_W != 8) begin : g_bad_width
      $error("pcm_compander: only 16/8 framing is supported");
   end
   if (MU_BIAS + MU_CLIP != 8192) begin : g_bad_bias
      $error("pcm_compander: mu-law bias and clip must sum to the 14-bit full scale");
   end

   logic [CODE_W-1:0] comp_code [NLAW];
   logic [WORD_W-1:0] exp_lin   [NLAW];
   law_e              law_sel;
   dir_e              dir_sel;
   logic [WORD_W-1:0] next_word;

   for (genvar L = 0; L < NLAW; L++) begin : g_law
      cmp_compress #(
         .IS_ALAW (L == 1),
         .WORD_W  (WORD_W),
         .CODE_W  (CODE_W),
         .MU_BIAS (MU_BIAS),
         .MU_CLIP (MU_CLIP)
      ) i_comp (
         .lin  (in_word),
         .code (comp_code[L])
      );
      cmp_expand #(
         .IS_ALAW (L == 1),
         .WORD_W  (WORD_W),
         .CODE_W  (CODE_W)
      ) i_exp (
         .code (in_word[CODE_W-1:0]),
         .lin  (exp_lin[L])
      );
   end

   always_comb begin
      law_sel = law_e'(in_law);
      dir_sel = dir_e'(in_dir);
      if (dir_sel == DIR_COMPRESS)
         next_word = {{FILL_W{1'b0}}, comp_code[law_sel]};
      else
         next_word = exp_lin[law_sel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_word <= next_word;
      end
   end

   // R2: one-cycle latency on the valid flag
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R10: result held in gaps
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_word));
   // R8: code framing
   a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dir) |=> (out_word[WORD_W-1:CODE_W] == '0));
   // R4 / R5: zero-filled low bits per law
   a_r4_mu_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_dir && !in_law) |=> (out_word[1:0] == 2'b00));
   a_r5_a_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_dir && in_law) |=> (out_word[2:0] == 3'b000));
   // R9: saturation at the negative extreme
   a_r9_mu_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dir && !in_law && in_word == 16'h8000) |=> (out_word == 16'h0000));
   a_r9_a_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dir && in_law && in_word == 16'h8000) |=> (out_word == 16'h002A));
   // R6 / R7: silence codes
   a_r6_mu_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dir && !in_law && in_word == 16'h0000) |=> (out_word == 16'h00FF));
   a_r7_a_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dir && in_law && in_word == 16'h0000) |=> (out_word == 16'h00D5));

endmodule

// File: tb/test_pcm_compander.sv
module test_pcm_compander;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_law = 1'b0;
   logic        in_dir = 1'b0;
   logic [15:0] in_word = 16'h0000;
   logic        out_valid;
   logic [15:0] out_word;

   int checks = 0;
   int errors = 0;

   // model state
   logic        m_valid = 1'b0;
   logic [15:0] m_word  = 16'h0000;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_compander i_pcm_compander (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_law    (in_law),
      .in_dir    (in_dir),
      .in_word   (in_word),
      .out_valid (out_valid),
      .out_word  (out_word)
   );

   // behavioural expansion: magnitude in units of the law's step
   function automatic logic [15:0] ref_expand(input bit alaw, input logic [7:0] c);
      int s, e, m, mag, res;
      if (!alaw) begin
         s = (c[7] == 1'b0) ? 1 : 0;                // 1 = negative
         e = 7 - int'(c[6:4]);
         m = 15 - int'(c[3:0]);
         mag = 4 * (((2*m + 33) << e) - 33);
         res = s ? -mag : mag;
      end else begin
         s = ((c[7] ^ 1'b0) == 1'b1) ? 0 : 1;       // bit7 of c^0x55 equals c[7]
         e = int'(c[6:4] ^ 3'b101);
         m = int'(c[3:0] ^ 4'b0101);
         mag = (e == 0) ? 8 * (2*m + 1) : 8 * ((2*m + 33) << (e - 1));
         res = s ? -mag : mag;
      end
      return 16'(res);
   endfunction

   function automatic logic [15:0] ref_compress(input bit alaw, input logic [15:0] w);
      int x, v, mag, e, mant, code;
      x = int'($signed(w));
      if (!alaw) begin
         v = x >>> 2;
         mag = (v < 0) ? -v : v;
         if (mag > 8159) mag = 8159;
         mag = mag + 33;
         e = 0;
         while (e < 8 && mag >= (64 << e)) e++;
         code = (e == 8) ? 127 : e*16 + ((mag >> (e+1)) % 16);
         code = code ^ ((v < 0) ? 127 : 255);
      end else begin
         v = x >>> 3;
         mag = (v < 0) ? -v - 1 : v;
         e = 0;
         while (e < 7 && mag >= (32 << e)) e++;
         mant = (e < 2) ? ((mag >> 1) % 16) : ((mag >> e) % 16);
         code = (e*16 + mant) ^ ((v < 0) ? 85 : 213);
      end
      return 16'(code);
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, update model at posedge, compare at next negedge
   task automatic step(input string req, input logic v, input logic law,
                       input logic dir, input logic [15:0] w);
      in_valid = v;
      in_law   = law;
      in_dir   = dir;
      in_word  = w;
      @(posedge clk);
      m_valid = v;
      if (v) m_word = dir ? ref_compress(law, w) : ref_expand(law, w[7:0]);
      @(negedge clk);
      check({req, " valid"}, {15'd0, out_valid}, {15'd0, m_valid});
      check(req, out_word, m_word);
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      check("R1 reset valid", {15'd0, out_valid}, 16'h0000);
      check("R1 reset word", out_word, 16'h0000);
      rst_n = 1'b1;
      step("R1", 1'b0, 1'b0, 1'b0, 16'h0000);
      check("R1 after release", out_word, 16'h0000);

      // fixed points
      step("R6", 1'b1, 1'b0, 1'b1, 16'h0000); check("R6 mu zero", out_word, 16'h00FF);
      step("R7", 1'b1, 1'b1, 1'b1, 16'h0000); check("R7 a zero", out_word, 16'h00D5);
      step("R6", 1'b1, 1'b0, 1'b1, 16'hFFFF); check("R6 mu minus one", out_word, 16'h007E);
      step("R7", 1'b1, 1'b1, 1'b1, 16'hFFFF); check("R7 a minus one", out_word, 16'h0055);
      step("R9", 1'b1, 1'b0, 1'b1, 16'h8000); check("R9 mu floor", out_word, 16'h0000);
      step("R9", 1'b1, 1'b1, 1'b1, 16'h8000); check("R9 a floor", out_word, 16'h002A);
      step("R9", 1'b1, 1'b0, 1'b1, 16'h7FFF); check("R9 mu ceiling", out_word, 16'h0080);
      step("R9", 1'b1, 1'b1, 1'b1, 16'h7FFF); check("R9 a ceiling", out_word, 16'h00AA);
      step("R4", 1'b1, 1'b0, 1'b0, 16'hAB00); check("R4 mu code 00", out_word, 16'h8284);
      step("R4", 1'b1, 1'b0, 1'b0, 16'h12FF); check("R4 mu code FF", out_word, 16'h0000);
      step("R5", 1'b1, 1'b1, 1'b0, 16'hCDD5); check("R5 a code D5", out_word, 16'h0008);
      step("R5", 1'b1, 1'b1, 1'b0, 16'h0155); check("R5 a code 55", out_word, 16'hFFF8);

      // R10: gap holds the last result
      step("R10", 1'b0, 1'b1, 1'b1, 16'h1234); check("R10 hold", out_word, 16'hFFF8);
      step("R2", 1'b0, 1'b0, 1'b0, 16'h0000);

      // R4 / R5: every code under both laws, junk upper byte
      for (int c = 0; c < 256; c++) begin
         step("R4", 1'b1, 1'b0, 1'b0, {8'(c * 37 + 5), 8'(c)});
         check("R4 lsb", {14'd0, out_word[1:0]}, 16'h0000);
         step("R5", 1'b1, 1'b1, 1'b0, {8'(c * 91 + 3), 8'(c)});
         check("R5 lsb", {13'd0, out_word[2:0]}, 16'h0000);
      end

      // R6 / R7 / R8: compression sweep across the signed range
      for (int k = 0; k < 1024; k++) begin
         logic [15:0] w;
         w = 16'(k * 64 + (k % 61));
         step("R6", 1'b1, 1'b0, 1'b1, w);
         check("R8 mu upper", {8'd0, out_word[15:8]}, 16'h0000);
         step("R7", 1'b1, 1'b1, 1'b1, w);
         check("R8 a upper", {8'd0, out_word[15:8]}, 16'h0000);
      end

      // R3 / R2 / R10: selects change every sample, gaps in between
      for (int k = 0; k < 600; k++) begin
         logic [15:0] w;
         w = 16'(k * 4099 + 17);
         step((k % 5 == 4) ? "R10" : "R3", (k % 5 != 4), 1'(k), 1'(k >> 1), w);
      end

      step("R2", 1'b0, 1'b0, 1'b0, 16'h0000);
      finish_run();
   end

endmodule